// File: doc/BRIEF.md
# Banked UART Register Window Decoder

This block sits between a host bus and the core of a 16550-style UART. It turns an eight-offset register window into the larger set of registers the UART really has. The register seen at an offset depends on the mode state held inside the block. The top bit of the line control register switches offsets 0 and 1 over to the baud divisor bytes. One special line control value opens the flow-control bank. A set of indexed control registers is reached through an index held at offset 7 and a data port at offset 5.

The block keeps the line control, divisor, enhanced-feature, flow-character, index and indexed control registers itself and drives them out to the core. Registers that live in the core (transmit data, interrupt enable, FIFO control, modem control, modem status, additional status) are handled differently. A write to one of them becomes a one-cycle strobe on a one-hot vector, together with the data. Reads of them return values the core supplies. Read data is registered and appears one cycle after the read strobe. The serial engine, the FIFOs and the baud generator are not part of this block.

Top module: `uart_bank_decoder`

## Requirements
- R1: After reset, every held register (line control, divisor bytes, enhanced features, the four flow characters, index, all indexed registers), `rdata`, `core_we` and `rx_pop` are zero.
- R2: While `lcr_q[7]` is 1, offsets 0 and 1 read and write the divisor low and high bytes. While it is 0, offset 0 reads `rx_data` and a write pulses `core_we[0]`. In the same mode, offset 1 reads `ier_in` and a write pulses `core_we[1]`. A read of offset 0 in this mode pulses `rx_pop` one cycle after `rd_en`.
- R3: While `lcr_q` is not 0xBF, offset 2 reads `iir_in` and a write pulses `core_we[2]`. While `lcr_q` equals 0xBF, offset 2 reads and writes the enhanced-feature register.
- R4: A write to offset 3 always updates `lcr_q`, whatever the mode. A read of offset 3 returns `lcr_q`, unless additional-control bit 7 is set; then it returns `rx_level`.
- R5: While `lcr_q` equals 0xBF, offsets 4, 5, 6 and 7 read and write flow characters 0 to 3. These appear on `flow_chars` in bytes [7:0], [15:8], [23:16] and [31:24]. Outside that mode, offset 4 reads `mcr_in` and a write pulses `core_we[3]`. Offset 6 reads `msr_in` and a write pulses `core_we[4]`. Offset 7 is the index register `spr_q`.
- R6: Outside the 0xBF mode, a write to offset 5 goes to the indexed register chosen by `spr_q`: 0 additional control, 1 prescaler, 2 clock multiplier, 4 transmit trigger, 5 receive trigger. Writes to any other index change nothing.
- R7: A read of offset 5 outside the 0xBF mode returns the indexed register chosen by `spr_q` when additional-control bit 6 is set. Undefined indices read as zero. When bit 6 is clear, the read returns `lsr_in`.
- R8: While additional-control bit 7 is set, offset 1 reads `asr_in` and a write pulses `core_we[5]` when `lcr_q[7]` is 0. In the same mode, offset 4 reads `tx_level` when `lcr_q` is not 0xBF.
- R9: Writes to the transmit and receive trigger registers (indices 4 and 5) take effect only while additional-control bit 5 is set.
- R10: `rdata` changes only one cycle after a cycle with `rd_en`, and holds otherwise. `core_we` is all zero or one-hot, and asserts one cycle after the `wr_en` that caused it. `core_wdata` carries the data of the last write.
- R11: When `rd_en` and `wr_en` are both high in one cycle, the read returns the mapping and value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Head of the receive FIFO from the core |
| ier_in | input | 8 | Interrupt enable value from the core |
| iir_in | input | 8 | Interrupt identification value from the core |
| mcr_in | input | 8 | Modem control value from the core |
| lsr_in | input | 8 | Line status value from the core |
| msr_in | input | 8 | Modem status value from the core |
| asr_in | input | 8 | Additional status value from the core |
| rx_level | input | 8 | Receive FIFO fill level |
| tx_level | input | 8 | Transmit FIFO fill level |
| core_we | output | 6 | One-hot core write strobes: 0 data, 1 int enable, 2 FIFO ctl, 3 modem ctl, 4 modem status, 5 add. status |
| core_wdata | output | 8 | Data for the core write strobes |
| rx_pop | output | 1 | Receive FIFO pop pulse |
| lcr_q | output | 8 | Line control register |
| dll_q | output | 8 | Divisor low byte |
| dlm_q | output | 8 | Divisor high byte |
| efr_q | output | 8 | Enhanced-feature register |
| flow_chars | output | 32 | Four flow-control characters |
| spr_q | output | 8 | Scratch / index register |
| acr_q | output | 8 | Additional control (index 0) |
| cpr_q | output | 8 | Clock prescaler (index 1) |
| tcr_q | output | 8 | Clock multiplier (index 2) |
| ttl_q | output | 8 | Transmit trigger level (index 4) |
| rtl_q | output | 8 | Receive trigger level (index 5) |

## Verification
There is a single address bus, so a read and a write can land on the same offset in the same cycle. The interesting case is when that write changes the mapping or the value being read. The bench writes 0xBF to offset 3 while reading it, and writes the index register while reading it. It expects the old contents in `rdata` and the new ones on the following read. A behavioural model in the bench always evaluates the read before it applies the write. It compares every output on every clock, so a design that lets the new mode leak into the same cycle's read data is caught at once.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  localparam int NUM_CORE = 6;
  localparam int NUM_FLOW = 4;

  // bit positions inside the additional control register
  localparam int ACR_STAT_BIT = 7;
  localparam int ACR_RDBK_BIT = 6;
  localparam int ACR_TRIG_BIT = 5;

  // indexed slot numbers
  localparam int IX_ACR = 0;
  localparam int IX_CPR = 1;
  localparam int IX_TCR = 2;
  localparam int IX_TTL = 4;
  localparam int IX_RTL = 5;

  typedef enum logic [2:0] {
    CT_THR = 3'd0,
    CT_IER = 3'd1,
    CT_FCR = 3'd2,
    CT_MCR = 3'd3,
    CT_MSR = 3'd4,
    CT_ASR = 3'd5
  } core_tgt_e;

  typedef enum logic [3:0] {
    RS_RBR, RS_DLL, RS_DLM, RS_IER, RS_ASR, RS_IIR, RS_EFR, RS_LCR,
    RS_RFL, RS_MCR, RS_TFL, RS_FLOW, RS_ICR, RS_LSR, RS_MSR, RS_SPR
  } rd_sel_e;

  typedef struct packed {
    logic       lcr;
    logic       dll;
    logic       dlm;
    logic       efr;
    logic       flow;
    logic       spr;
    logic       icr;
    logic       core;
    core_tgt_e  tgt;
    logic [1:0] flow_idx;
  } wr_dec_t;

endpackage

// File: rtl/ubd_decode.sv
module ubd_decode
  import uart_bank_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [7:0]  EFR_KEY = 8'hBF
) (
  input  logic [2:0]    addr,
  input  logic [DW-1:0] lcr_q,
  input  logic [DW-1:0] acr_q,
  output wr_dec_t       wdec,
  output rd_sel_e       rsel,
  output logic [1:0]    flow_idx,
  output logic          rd_pop
);

  logic dlab, efr_mode, stat_en;

  assign dlab     = lcr_q[DW-1];
  assign efr_mode = (lcr_q == DW'(EFR_KEY));
  assign stat_en  = acr_q[ACR_STAT_BIT];
  assign flow_idx = addr[1:0];

  always_comb begin
    wdec          = '0;
    wdec.tgt      = CT_THR;
    wdec.flow_idx = addr[1:0];
    rsel          = RS_LCR;
    rd_pop        = 1'b0;
    case (addr)
      3'd0: begin
        if (dlab) begin
          wdec.dll = 1'b1;
          rsel     = RS_DLL;
        end else begin
          wdec.core = 1'b1;
          wdec.tgt  = CT_THR;
          rsel      = RS_RBR;
          rd_pop    = 1'b1;
        end
      end
      3'd1: begin
        if (dlab) begin
          wdec.dlm = 1'b1;
          rsel     = RS_DLM;
        end else if (stat_en) begin
          wdec.core = 1'b1;
          wdec.tgt  = CT_ASR;
          rsel      = RS_ASR;
        end else begin
          wdec.core = 1'b1;
          wdec.tgt  = CT_IER;
          rsel      = RS_IER;
        end
      end
      3'd2: begin
        if (efr_mode) begin
          wdec.efr = 1'b1;
          rsel     = RS_EFR;
        end else begin
          wdec.core = 1'b1;
          wdec.tgt  = CT_FCR;
          rsel      = RS_IIR;
        end
      end
      3'd3: begin
        wdec.lcr = 1'b1;
        rsel     = stat_en ? RS_RFL : RS_LCR;
      end
      default: begin
        if (efr_mode) begin
          wdec.flow = 1'b1;
          rsel      = RS_FLOW;
        end else begin
          case (addr[1:0])
            2'd0: begin
              wdec.core = 1'b1;
              wdec.tgt  = CT_MCR;
              rsel      = stat_en ? RS_TFL : RS_MCR;
            end
            2'd1: begin
              wdec.icr = 1'b1;
              rsel     = acr_q[ACR_RDBK_BIT] ? RS_ICR : RS_LSR;
            end
            2'd2: begin
              wdec.core = 1'b1;
              wdec.tgt  = CT_MSR;
              rsel      = RS_MSR;
            end
            default: begin
              wdec.spr = 1'b1;
              rsel     = RS_SPR;
            end
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/ubd_regs.sv
module ubd_regs
  import uart_bank_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          NIDX      = 8,
  parameter logic [7:0]  IDX_MASK  = 8'b0011_0111,
  parameter logic [7:0]  TRIG_MASK = 8'b0011_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  wr_dec_t       wdec,
  output logic [DW-1:0] lcr_q,
  output logic [DW-1:0] dll_q,
  output logic [DW-1:0] dlm_q,
  output logic [DW-1:0] efr_q,
  output logic [DW-1:0] flow_q [NUM_FLOW],
  output logic [DW-1:0] spr_q,
  output logic [DW-1:0] idx_q  [NIDX]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q <= '0;
      dll_q <= '0;
      dlm_q <= '0;
      efr_q <= '0;
      spr_q <= '0;
    end else if (wr_en) begin
      if (wdec.lcr) lcr_q <= wdata;
      if (wdec.dll) dll_q <= wdata;
      if (wdec.dlm) dlm_q <= wdata;
      if (wdec.efr) efr_q <= wdata;
      if (wdec.spr) spr_q <= wdata;
    end
  end

  for (genvar f = 0; f < NUM_FLOW; f++) begin : g_flow
    always_ff @(posedge clk) begin
      if (rst)
        flow_q[f] <= '0;
      else if (wr_en && wdec.flow && (wdec.flow_idx == 2'(f)))
        flow_q[f] <= wdata;
    end
  end

  logic trig_open;
  assign trig_open = idx_q[IX_ACR][ACR_TRIG_BIT];

  for (genvar i = 0; i < NIDX; i++) begin : g_idx
    if (IDX_MASK[i]) begin : g_live
      logic gate;
      assign gate = TRIG_MASK[i] ? trig_open : 1'b1;
      always_ff @(posedge clk) begin
        if (rst)
          idx_q[i] <= '0;
        else if (wr_en && wdec.icr && (spr_q == DW'(i)) && gate)
          idx_q[i] <= wdata;
      end
    end else begin : g_hole
      assign idx_q[i] = '0;
    end
  end

endmodule

// File: rtl/ubd_rdmux.sv
module ubd_rdmux
  import uart_bank_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NIDX = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  rd_sel_e       rsel,
  input  logic [1:0]    flow_idx,
  input  logic          rd_pop,
  input  logic [DW-1:0] lcr_q,
  input  logic [DW-1:0] dll_q,
  input  logic [DW-1:0] dlm_q,
  input  logic [DW-1:0] efr_q,
  input  logic [DW-1:0] flow_q [NUM_FLOW],
  input  logic [DW-1:0] spr_q,
  input  logic [DW-1:0] idx_q  [NIDX],
  input  logic [DW-1:0] rx_data,
  input  logic [DW-1:0] ier_in,
  input  logic [DW-1:0] iir_in,
  input  logic [DW-1:0] mcr_in,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  input  logic [DW-1:0] asr_in,
  input  logic [DW-1:0] rx_level,
  input  logic [DW-1:0] tx_level,
  output logic [DW-1:0] rdata,
  output logic          rx_pop
);

  localparam int IW = (NIDX > 1) ? $clog2(NIDX) : 1;

  logic          idx_hit;
  logic [DW-1:0] idx_val;
  logic [DW-1:0] mux_out;

  assign idx_hit = ((spr_q >> IW) == '0);
  assign idx_val = idx_hit ? idx_q[spr_q[IW-1:0]] : '0;

  always_comb begin
    case (rsel)
      RS_RBR:  mux_out = rx_data;
      RS_DLL:  mux_out = dll_q;
      RS_DLM:  mux_out = dlm_q;
      RS_IER:  mux_out = ier_in;
      RS_ASR:  mux_out = asr_in;
      RS_IIR:  mux_out = iir_in;
      RS_EFR:  mux_out = efr_q;
      RS_LCR:  mux_out = lcr_q;
      RS_RFL:  mux_out = rx_level;
      RS_MCR:  mux_out = mcr_in;
      RS_TFL:  mux_out = tx_level;
      RS_FLOW: mux_out = flow_q[flow_idx];
      RS_ICR:  mux_out = idx_val;
      RS_LSR:  mux_out = lsr_in;
      RS_MSR:  mux_out = msr_in;
      RS_SPR:  mux_out = spr_q;
      default: mux_out = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rx_pop <= 1'b0;
    end else begin
      rx_pop <= rd_en && rd_pop;
      if (rd_en) rdata <= mux_out;
    end
  end

endmodule

// File: rtl/uart_bank_decoder.sv
module uart_bank_decoder
  import uart_bank_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          NIDX      = 8,
  parameter logic [7:0]  EFR_KEY   = 8'hBF,
  parameter logic [7:0]  IDX_MASK  = 8'b0011_0111,
  parameter logic [7:0]  TRIG_MASK = 8'b0011_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           addr,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [DW-1:0]        rx_data,
  input  logic [DW-1:0]        ier_in,
  input  logic [DW-1:0]        iir_in,
  input  logic [DW-1:0]        mcr_in,
  input  logic [DW-1:0]        lsr_in,
  input  logic [DW-1:0]        msr_in,
  input  logic [DW-1:0]        asr_in,
  input  logic [DW-1:0]        rx_level,
  input  logic [DW-1:0]        tx_level,
  output logic [NUM_CORE-1:0]  core_we,
  output logic [DW-1:0]        core_wdata,
  output logic                 rx_pop,
  output logic [DW-1:0]        lcr_q,
  output logic [DW-1:0]        dll_q,
  output logic [DW-1:0]        dlm_q,
  output logic [DW-1:0]        efr_q,
  output logic [NUM_FLOW*DW-1:0] flow_chars,
  output logic [DW-1:0]        spr_q,
  output logic [DW-1:0]        acr_q,
  output logic [DW-1:0]        cpr_q,
  output logic [DW-1:0]        tcr_q,
  output logic [DW-1:0]        ttl_q,
  output logic [DW-1:0]        rtl_q
);

  wr_dec_t       wdec;
  rd_sel_e       rsel;
  logic [1:0]    flow_idx;
  logic          rd_pop;
  logic [DW-1:0] flow_q [NUM_FLOW];
  logic [DW-1:0] idx_q  [NIDX];

  ubd_decode #(.DW(DW), .EFR_KEY(EFR_KEY)) u_decode (
    .addr     (addr),
    .lcr_q    (lcr_q),
    .acr_q    (acr_q),
    .wdec     (wdec),
    .rsel     (rsel),
    .flow_idx (flow_idx),
    .rd_pop   (rd_pop)
  );

  ubd_regs #(.DW(DW), .NIDX(NIDX), .IDX_MASK(IDX_MASK), .TRIG_MASK(TRIG_MASK)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .wdec   (wdec),
    .lcr_q  (lcr_q),
    .dll_q  (dll_q),
    .dlm_q  (dlm_q),
    .efr_q  (efr_q),
    .flow_q (flow_q),
    .spr_q  (spr_q),
    .idx_q  (idx_q)
  );

  ubd_rdmux #(.DW(DW), .NIDX(NIDX)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rsel     (rsel),
    .flow_idx (flow_idx),
    .rd_pop   (rd_pop),
    .lcr_q    (lcr_q),
    .dll_q    (dll_q),
    .dlm_q    (dlm_q),
    .efr_q    (efr_q),
    .flow_q   (flow_q),
    .spr_q    (spr_q),
    .idx_q    (idx_q),
    .rx_data  (rx_data),
    .ier_in   (ier_in),
    .iir_in   (iir_in),
    .mcr_in   (mcr_in),
    .lsr_in   (lsr_in),
    .msr_in   (msr_in),
    .asr_in   (asr_in),
    .rx_level (rx_level),
    .tx_level (tx_level),
    .rdata    (rdata),
    .rx_pop   (rx_pop)
  );

  for (genvar f = 0; f < NUM_FLOW; f++) begin : g_pack
    assign flow_chars[f*DW +: DW] = flow_q[f];
  end

  assign acr_q = idx_q[IX_ACR];
  assign cpr_q = idx_q[IX_CPR];
  assign tcr_q = idx_q[IX_TCR];
  assign ttl_q = idx_q[IX_TTL];
  assign rtl_q = idx_q[IX_RTL];

  always_ff @(posedge clk) begin
    if (rst) begin
      core_we    <= '0;
      core_wdata <= '0;
    end else begin
      core_we <= '0;
      if (wr_en) begin
        core_wdata <= wdata;
        if (wdec.core) core_we[wdec.tgt] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ubd_checker.sv
module ubd_checker (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [7:0]  asr_in,
  input logic [5:0]  core_we,
  input logic        rx_pop,
  input logic [7:0]  lcr_q,
  input logic [31:0] flow_chars,
  input logic [7:0]  spr_q,
  input logic [7:0]  acr_q,
  input logic [7:0]  cpr_q,
  input logic [7:0]  ttl_q
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (lcr_q == 8'h00 && acr_q == 8'h00 && flow_chars == 32'h0 &&
               rdata == 8'h00 && core_we == 6'h00 && !rx_pop));

  assert_pop_source_R2: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> ($past(rd_en) && $past(addr) == 3'd0 && !$past(lcr_q[7])));

  assert_lcr_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd3) |=> (lcr_q == $past(wdata)));

  assert_flow_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd4 && lcr_q == 8'hBF) |=> (flow_chars[7:0] == $past(wdata)));

  assert_index_readback_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == 3'd5 && lcr_q != 8'hBF && acr_q[6] && spr_q == 8'd1)
      |=> (rdata == $past(cpr_q)));

  assert_status_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd1 && !lcr_q[7] && acr_q[7]) |=> (rdata == $past(asr_in)));

  assert_trigger_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd5 && lcr_q != 8'hBF && spr_q == 8'd4 && !acr_q[5])
      |=> $stable(ttl_q));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_we_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_we));

  assert_we_needs_wr_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (core_we == 6'h00));

endmodule

bind uart_bank_decoder ubd_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .asr_in     (asr_in),
  .core_we    (core_we),
  .rx_pop     (rx_pop),
  .lcr_q      (lcr_q),
  .flow_chars (flow_chars),
  .spr_q      (spr_q),
  .acr_q      (acr_q),
  .cpr_q      (cpr_q),
  .ttl_q      (ttl_q)
);

// File: tb/uart_bank_decoder_bench.sv
module uart_bank_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  rx_data  = 8'h5A;
  logic [7:0]  ier_in   = 8'h05;
  logic [7:0]  iir_in   = 8'hC1;
  logic [7:0]  mcr_in   = 8'h0B;
  logic [7:0]  lsr_in   = 8'h60;
  logic [7:0]  msr_in   = 8'hB0;
  logic [7:0]  asr_in   = 8'h03;
  logic [7:0]  rx_level = 8'h11;
  logic [7:0]  tx_level = 8'h22;
  logic [5:0]  core_we;
  logic [7:0]  core_wdata;
  logic        rx_pop;
  logic [7:0]  lcr_q, dll_q, dlm_q, efr_q, spr_q, acr_q, cpr_q, tcr_q, ttl_q, rtl_q;
  logic [31:0] flow_chars;

  always #10 clk = ~clk;

  uart_bank_decoder u_uart_bank_decoder (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .ier_in(ier_in),
    .iir_in(iir_in), .mcr_in(mcr_in), .lsr_in(lsr_in), .msr_in(msr_in),
    .asr_in(asr_in), .rx_level(rx_level), .tx_level(tx_level),
    .core_we(core_we), .core_wdata(core_wdata), .rx_pop(rx_pop),
    .lcr_q(lcr_q), .dll_q(dll_q), .dlm_q(dlm_q), .efr_q(efr_q),
    .flow_chars(flow_chars), .spr_q(spr_q), .acr_q(acr_q), .cpr_q(cpr_q),
    .tcr_q(tcr_q), .ttl_q(ttl_q), .rtl_q(rtl_q)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int m_lcr, m_dll, m_dlm, m_efr, m_spr;
  int m_flow [4];
  int m_idx  [8];
  int e_rdata, e_we, e_wdata, e_pop;

  task automatic model_reset();
    m_lcr = 0; m_dll = 0; m_dlm = 0; m_efr = 0; m_spr = 0;
    foreach (m_flow[k]) m_flow[k] = 0;
    foreach (m_idx[k])  m_idx[k]  = 0;
    e_rdata = 0; e_we = 0; e_wdata = 0; e_pop = 0;
  endtask

  function automatic int model_read(int a);
    bit dl, bf, st, rb;
    dl = (m_lcr & 8'h80) != 0;
    bf = (m_lcr == 8'hBF);
    st = (m_idx[0] & 8'h80) != 0;
    rb = (m_idx[0] & 8'h40) != 0;
    case (a)
      0: return dl ? m_dll : rx_data;
      1: return dl ? m_dlm : (st ? asr_in : ier_in);
      2: return bf ? m_efr : iir_in;
      3: return st ? rx_level : m_lcr;
      4: return bf ? m_flow[0] : (st ? tx_level : mcr_in);
      5: return bf ? m_flow[1] : (rb ? ((m_spr < 8) ? m_idx[m_spr] : 0) : lsr_in);
      6: return bf ? m_flow[2] : msr_in;
      default: return bf ? m_flow[3] : m_spr;
    endcase
  endfunction

  // returns core strobe bit index or -1
  function automatic int model_write(int a, int d);
    bit dl, bf, st;
    dl = (m_lcr & 8'h80) != 0;
    bf = (m_lcr == 8'hBF);
    st = (m_idx[0] & 8'h80) != 0;
    case (a)
      0: if (dl) m_dll = d; else return 0;
      1: if (dl) m_dlm = d; else return st ? 5 : 1;
      2: if (bf) m_efr = d; else return 2;
      3: m_lcr = d;
      4: if (bf) m_flow[0] = d; else return 3;
      5: if (bf) m_flow[1] = d;
         else if (m_spr == 0 || m_spr == 1 || m_spr == 2) m_idx[m_spr] = d;
         else if ((m_spr == 4 || m_spr == 5) && (m_idx[0] & 8'h20) != 0) m_idx[m_spr] = d;
      6: if (bf) m_flow[2] = d; else return 4;
      default: if (bf) m_flow[3] = d; else m_spr = d;
    endcase
    return -1;
  endfunction

  task automatic compare(string tag);
    logic [31:0] e_flow;
    bit ok;
    e_flow = {m_flow[3][7:0], m_flow[2][7:0], m_flow[1][7:0], m_flow[0][7:0]};
    ok = (rdata == 8'(e_rdata)) && (core_we == 6'(e_we)) && (core_wdata == 8'(e_wdata)) &&
         (rx_pop == 1'(e_pop)) && (lcr_q == 8'(m_lcr)) && (dll_q == 8'(m_dll)) &&
         (dlm_q == 8'(m_dlm)) && (efr_q == 8'(m_efr)) && (flow_chars == e_flow) &&
         (spr_q == 8'(m_spr)) && (acr_q == 8'(m_idx[0])) && (cpr_q == 8'(m_idx[1])) &&
         (tcr_q == 8'(m_idx[2])) && (ttl_q == 8'(m_idx[4])) && (rtl_q == 8'(m_idx[5]));
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: rdata=%h/%h we=%b/%b wd=%h/%h pop=%b/%b lcr=%h/%h div=%h%h/%h%h efr=%h/%h flow=%h/%h spr=%h/%h idx=%h %h %h %h %h/%h %h %h %h %h (actual/expected)",
        tag, rdata, 8'(e_rdata), core_we, 6'(e_we), core_wdata, 8'(e_wdata), rx_pop, 1'(e_pop),
        lcr_q, 8'(m_lcr), dlm_q, dll_q, 8'(m_dlm), 8'(m_dll), efr_q, 8'(m_efr), flow_chars, e_flow,
        spr_q, 8'(m_spr), acr_q, cpr_q, tcr_q, ttl_q, rtl_q,
        8'(m_idx[0]), 8'(m_idx[1]), 8'(m_idx[2]), 8'(m_idx[4]), 8'(m_idx[5]));
    end
  endtask

  // one clock: drive at negedge, model the edge, sample at next negedge
  task automatic step(bit rd, bit wr, int a, int d, string tag);
    int tgt;
    rd_en = rd; wr_en = wr; addr = 3'(a); wdata = 8'(d);
    e_pop = (rd && a == 0 && (m_lcr & 8'h80) == 0) ? 1 : 0;
    if (rd) e_rdata = model_read(a);
    e_we = 0;
    if (wr) begin
      e_wdata = d;
      tgt = model_write(a, d);
      if (tgt >= 0) e_we = 1 << tgt;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(int a, string tag);  step(1'b1, 1'b0, a, 0, tag); endtask
  task automatic wr(int a, int d, string tag); step(1'b0, 1'b1, a, d, tag); endtask

  task automatic do_reset();
    rd_en = 1'b0; wr_en = 1'b0; rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    compare("R1 reset");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    step(1'b0, 1'b0, 0, 0, "R1 idle");

    // normal bank reads (R2 R3 R4 R5 R7)
    rd(0, "R2 data read pops");
    rd(1, "R2 ier read");
    rd(2, "R3 iir read");
    rd(3, "R4 lcr read");
    rd(4, "R5 mcr read");
    rd(5, "R7 lsr when readback off");
    rd(6, "R5 msr read");
    rd(7, "R5 spr read");
    step(1'b0, 1'b0, 0, 0, "R10 rdata holds");

    // normal bank core strobes
    wr(0, 8'h41, "R2 thr strobe");
    wr(1, 8'h0F, "R2 ier strobe");
    wr(2, 8'hC7, "R3 fcr strobe");
    wr(4, 8'h03, "R5 mcr strobe");
    wr(6, 8'h00, "R5 msr strobe");
    step(1'b0, 1'b0, 0, 0, "R10 strobe clears");
    wr(7, 8'h6E, "R5 spr write");
    rd(7, "R5 spr readback");

    // divisor bank
    wr(3, 8'h83, "R4 set dlab");
    wr(0, 8'h34, "R2 dll write");
    wr(1, 8'h12, "R2 dlm write");
    rd(0, "R2 dll read no pop");
    rd(1, "R2 dlm read");
    rd(2, "R3 iir under dlab");
    rd(4, "R5 mcr under dlab");

    // flow-control bank
    wr(3, 8'hBF, "R3 enter key mode");
    wr(2, 8'h10, "R3 efr write");
    rd(2, "R3 efr read");
    for (int k = 0; k < 4; k++) wr(4 + k, 8'hA1 + k, "R5 flow write");
    for (int k = 0; k < 4; k++) rd(4 + k, "R5 flow read");
    rd(0, "R2 dll in key mode");
    wr(3, 8'h03, "R4 leave key mode");
    rd(2, "R3 iir again");
    rd(4, "R5 mcr again");
    rd(7, "R5 spr kept");

    // same-cycle read and write (R11)
    step(1'b1, 1'b1, 3, 8'hBF, "R11 read sees old lcr");
    rd(3, "R11 new lcr visible");
    rd(5, "R11 key mode mapping after");
    wr(3, 8'h03, "R4 back to normal");
    step(1'b1, 1'b1, 7, 8'h09, "R11 read sees old spr");
    rd(7, "R11 new spr visible");

    // indexed set (R6 R7 R9)
    wr(5, 8'h77, "R6 undefined index ignored");
    wr(7, 8'h00, "R6 point at acr");
    wr(5, 8'h40, "R6 acr write readback on");
    rd(5, "R7 acr readback");
    wr(7, 8'h01, "R6 point at cpr");
    wr(5, 8'h07, "R6 cpr write");
    rd(5, "R7 cpr readback");
    wr(7, 8'h02, "R6 point at tcr");
    wr(5, 8'h0C, "R6 tcr write");
    rd(5, "R7 tcr readback");
    wr(7, 8'h03, "R6 point at hole");
    wr(5, 8'h99, "R6 hole write ignored");
    rd(5, "R7 hole reads zero");
    wr(7, 8'h04, "R9 point at ttl");
    wr(5, 8'h20, "R9 ttl locked");
    rd(5, "R9 ttl still zero");
    wr(7, 8'h00, "R6 point at acr");
    wr(5, 8'h60, "R9 open triggers");
    wr(7, 8'h04, "R9 point at ttl");
    wr(5, 8'h20, "R9 ttl write");
    rd(5, "R9 ttl readback");
    wr(7, 8'h05, "R9 point at rtl");
    wr(5, 8'h30, "R9 rtl write");
    rd(5, "R9 rtl readback");
    wr(7, 8'h0D, "R7 out of range index");
    rd(5, "R7 out of range reads zero");

    // status read mapping (R8)
    wr(7, 8'h00, "R6 point at acr");
    wr(5, 8'hE0, "R8 enable status");
    rd(1, "R8 asr read");
    rd(3, "R4 rfl read");
    rd(4, "R8 tfl read");
    wr(1, 8'h02, "R8 asr strobe");
    wr(3, 8'h1B, "R4 lcr write under status");
    rd(3, "R4 still rfl");
    wr(3, 8'h80, "R4 dlab under status");
    rd(1, "R8 dlm wins over asr");
    wr(3, 8'hBF, "R8 key mode under status");
    rd(4, "R8 flow wins over tfl");
    rd(3, "R4 rfl in key mode");
    wr(3, 8'h00, "R4 exit");
    wr(5, 8'h00, "R6 clear acr");
    rd(1, "R2 ier back");
    rd(5, "R7 lsr back");

    // mid-run reset
    do_reset();
    rd(7, "R1 spr zero after reset");
    rd(5, "R1 lsr after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule